// File: doc/BRIEF.md
# Lookup Table Index Remasking Engine

This block keeps a small lookup table in local storage and re-keys its index on demand. A lookup table whose entries are already protected by a fixed output mask is loaded once through a write port. Afterwards, whenever a fresh random index mask M is supplied with a start pulse, the engine rearranges the entries in place so that the entry formerly found at index b is now found at index b XOR M. Contents are never altered, only relocated. Remaskings accumulate: each run applies its mask on top of the arrangement left by the previous one.

The rearrangement is a series of conditional block exchanges. For every set bit i of M, the table is treated as consecutive blocks of 2^i entries, and each even-numbered block trades places with the block after it. Zero bits cost one decision cycle and move nothing. The bits are visited in an order derived from a random seed, so the sequence of memory activity differs from run to run while the end result stays the same. One entry pair is exchanged per three cycles: both entries are fetched, then the low slot is written, then the high slot. A parameter selects the address width, which covers both the 256-entry byte table and the 16-entry nibble table.

Random values are produced elsewhere and arrive on the mask and seed ports. While the engine is busy, lookups are refused: the read port holds its last value and the valid flag stays low.

Top module: `remask_engine`

## Requirements
- R1: After reset, busy, done and rd_valid are low and every table entry reads as zero.
- R2: While idle, a wr_en cycle stores wr_data at wr_addr. A lookup presented on rd_addr returns the entry on rd_data with rd_valid high one clock later.
- R3: When done rises, the entry at index b XOR M equals the entry that was at index b when the start was accepted, for every index b and every seed. Entry values are moved unchanged.
- R4: A mask of zero leaves every entry where it was.
- R5: Each of the ADDR_W mask bits is visited exactly once per run. The visit order is k-th bit = (seed[IDX_W-1:0] + k*stride) mod ADDR_W, where stride is seed[SEED_W-1:IDX_W] followed by a 1 bit, which makes it odd. The result does not depend on the seed.
- R6: done is high exactly ADDR_W + 3*(2^(ADDR_W-1))*popcount(M) clocks after the clock edge that accepts start.
- R7: done is a one-cycle pulse. busy is high from the cycle after the accepting edge through the done cycle, and low in the cycle after done.
- R8: A start pulse while busy is ignored: it changes neither the running mask nor the result, and it produces no extra done.
- R9: Writes presented while busy are ignored and do not change the table.
- R10: While busy, rd_valid is low and rd_data holds the value it had when the run began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a remask run (accepted when idle) |
| mask | input | ADDR_W | Fresh index mask M |
| seed | input | SEED_W | Random value selecting the bit visit order |
| wr_en | input | 1 | Table load strobe (idle only) |
| wr_addr | input | ADDR_W | Table load index |
| wr_data | input | DATA_W | Table load value |
| rd_addr | input | ADDR_W | Lookup index |
| rd_data | output | DATA_W | Lookup result, registered |
| rd_valid | output | 1 | rd_data reflects a lookup made while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The bench builds the engine with ADDR_W=4 and DATA_W=4. This is the 16-entry nibble variant, where the index space is small enough to sweep every one of the 16 masks and all 8 seeds. Because the 16-entry table is read back in full after every run, each entry's expected position under the accumulated XOR of all masks is checked, and the latency formula is checked at every popcount from 0 to 4. The same small setting keeps start-while-busy, write-while-busy and held-lookup cases cheap enough to run inside ordinary runs.

// File: rtl/remask_pkg.sv
package remask_pkg;

    // Smallest supported index width: the stride field needs IDX_W >= 2.
    localparam int unsigned MIN_ADDR_W = 4;

    // Cycles spent on one entry pair: fetch both, write low, write high.
    localparam int unsigned PAIR_CYCLES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_FETCH,
        ST_PUT_LO,
        ST_PUT_HI,
        ST_FINISH
    } eng_state_e;

    // Latched run parameters.
    typedef struct packed {
        logic [7:0] mask;
        logic [2:0] offset;
        logic [2:0] stride;
    } run_cfg_t;

endpackage

// File: rtl/remask_store.sv
module remask_store
    import remask_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [1:0][ADDR_W-1:0]      eaddr,
    output logic [1:0][DATA_W-1:0]      edata,
    input  logic                        rd_allow,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rd_data,
    output logic                        rd_valid
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Two combinational fetch ports for the engine.
    for (genvar p = 0; p < 2; p++) begin : g_fetch
        assign edata[p] = cells[eaddr[p]];
    end

    // Registered lookup port; holds its value when not allowed.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_allow;
            if (rd_allow) begin
                rd_data <= cells[rd_addr];
            end
        end
    end

endmodule

// File: rtl/remask_order.sv
module remask_order #(
    parameter int unsigned IDX_W = 3
) (
    input  logic [IDX_W-1:0] offset,
    input  logic [IDX_W-1:0] stride,
    input  logic [IDX_W-1:0] step,
    output logic [IDX_W-1:0] bit_idx
);
    // Odd stride is coprime with a power-of-two bit count, so the
    // sequence offset + k*stride walks every bit exactly once.
    logic [2*IDX_W-1:0] prod;

    always_comb begin
        prod    = step * stride;
        bit_idx = offset + prod[IDX_W-1:0];
    end

endmodule

// File: rtl/remask_ctrl.sv
module remask_ctrl
    import remask_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [ADDR_W-1:0]            mask,
    input  logic [2*$clog2(ADDR_W)-2:0]  seed,
    input  logic [1:0][DATA_W-1:0]       edata,
    output logic [1:0][ADDR_W-1:0]       eaddr,
    output logic                         eng_we,
    output logic [ADDR_W-1:0]            eng_waddr,
    output logic [DATA_W-1:0]            eng_wdata,
    output logic                         busy,
    output logic                         done,
    output logic                         pick_fire,
    output logic [$clog2(ADDR_W)-1:0]    pick_bit
);
    localparam int unsigned IDX_W  = $clog2(ADDR_W);
    localparam int unsigned SEED_W = 2 * IDX_W - 1;
    localparam int unsigned PAIR_W = ADDR_W - 1;

    typedef struct packed {
        logic [IDX_W-1:0]  step;
        logic [IDX_W-1:0]  bsel;
        logic [PAIR_W-1:0] pair;
    } walk_t;

    eng_state_e        st;
    logic [ADDR_W-1:0] mask_q;
    logic [IDX_W-1:0]  off_q;
    logic [IDX_W-1:0]  stride_q;
    walk_t             walk;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;

    logic [IDX_W-1:0]  cur_bit;
    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              step_last;
    logic              pair_last;

    remask_order #(.IDX_W(IDX_W)) u_order (
        .offset  (off_q),
        .stride  (stride_q),
        .step    (walk.step),
        .bit_idx (cur_bit)
    );

    // Spread pair number around a zero at position bsel.
    function automatic logic [ADDR_W-1:0] spread_pair(
        input logic [PAIR_W-1:0] p,
        input logic [IDX_W-1:0]  b
    );
        logic [ADDR_W-1:0] pe;
        logic [ADDR_W-1:0] r;
        pe   = {1'b0, p};
        r    = '0;
        r[0] = (b == '0) ? 1'b0 : pe[0];
        for (int j = 1; j < ADDR_W; j++) begin
            if (IDX_W'(j) < b) begin
                r[j] = pe[j];
            end else if (IDX_W'(j) == b) begin
                r[j] = 1'b0;
            end else begin
                r[j] = pe[j-1];
            end
        end
        return r;
    endfunction

    always_comb begin
        lo_addr   = spread_pair(walk.pair, walk.bsel);
        hi_addr   = lo_addr | (ADDR_W'(1) << walk.bsel);
        step_last = (walk.step == IDX_W'(ADDR_W - 1));
        pair_last = &walk.pair;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            mask_q   <= '0;
            off_q    <= '0;
            stride_q <= '0;
            walk     <= '0;
            lo_q     <= '0;
            hi_q     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        mask_q    <= mask;
                        off_q     <= seed[IDX_W-1:0];
                        stride_q  <= {seed[SEED_W-1:IDX_W], 1'b1};
                        walk.step <= '0;
                        st        <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    walk.bsel <= cur_bit;
                    walk.pair <= '0;
                    if (mask_q[cur_bit]) begin
                        st <= ST_FETCH;
                    end else if (step_last) begin
                        st <= ST_FINISH;
                    end else begin
                        walk.step <= walk.step + 1'b1;
                    end
                end
                ST_FETCH: begin
                    lo_q <= edata[0];
                    hi_q <= edata[1];
                    st   <= ST_PUT_LO;
                end
                ST_PUT_LO: begin
                    st <= ST_PUT_HI;
                end
                ST_PUT_HI: begin
                    if (!pair_last) begin
                        walk.pair <= walk.pair + 1'b1;
                        st        <= ST_FETCH;
                    end else if (step_last) begin
                        st <= ST_FINISH;
                    end else begin
                        walk.step <= walk.step + 1'b1;
                        st        <= ST_PICK;
                    end
                end
                ST_FINISH: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        eaddr[0]  = lo_addr;
        eaddr[1]  = hi_addr;
        eng_we    = (st == ST_PUT_LO) || (st == ST_PUT_HI);
        eng_waddr = (st == ST_PUT_LO) ? lo_addr : hi_addr;
        eng_wdata = (st == ST_PUT_LO) ? hi_q : lo_q;
        busy      = (st != ST_IDLE);
        done      = (st == ST_FINISH);
        pick_fire = (st == ST_PICK);
        pick_bit  = cur_bit;
    end

endmodule

// File: rtl/remask_engine.sv
module remask_engine
    import remask_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W  = $clog2(ADDR_W),
    localparam int unsigned SEED_W = 2 * IDX_W - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] mask,
    input  logic [SEED_W-1:0] seed,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              busy,
    output logic              done
);
    logic [1:0][ADDR_W-1:0] eaddr;
    logic [1:0][DATA_W-1:0] edata;
    logic                   eng_we;
    logic [ADDR_W-1:0]      eng_waddr;
    logic [DATA_W-1:0]      eng_wdata;
    logic                   pick_fire;
    logic [IDX_W-1:0]       pick_bit;

    logic                   st_we;
    logic [ADDR_W-1:0]      st_waddr;
    logic [DATA_W-1:0]      st_wdata;
    logic                   rd_allow;

    remask_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mask      (mask),
        .seed      (seed),
        .edata     (edata),
        .eaddr     (eaddr),
        .eng_we    (eng_we),
        .eng_waddr (eng_waddr),
        .eng_wdata (eng_wdata),
        .busy      (busy),
        .done      (done),
        .pick_fire (pick_fire),
        .pick_bit  (pick_bit)
    );

    // Engine owns the write port while busy; loads only when idle.
    always_comb begin
        st_we    = busy ? eng_we    : wr_en;
        st_waddr = busy ? eng_waddr : wr_addr;
        st_wdata = busy ? eng_wdata : wr_data;
        rd_allow = !busy && !start;
    end

    remask_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (st_we),
        .waddr    (st_waddr),
        .wdata    (st_wdata),
        .eaddr    (eaddr),
        .edata    (edata),
        .rd_allow (rd_allow),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/remask_engine_chk.sv
module remask_engine_chk #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned IDX_W = $clog2(ADDR_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              eng_we,
    input logic              pick_fire,
    input logic [IDX_W-1:0]  pick_bit
);
    logic [ADDR_W-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= '0;
        end else if (start && !busy) begin
            seen <= '0;
        end else if (pick_fire) begin
            seen[pick_bit] <= 1'b1;
        end
    end

    // R5: no mask bit is visited twice in a run
    a_r5_no_repeat: assert property (@(posedge clk) disable iff (rst)
        pick_fire |-> !seen[pick_bit]);

    // R5: every mask bit has been visited by the done cycle
    a_r5_all_visited: assert property (@(posedge clk) disable iff (rst)
        done |-> (&seen));

    // R7: done lasts one cycle and busy drops after it
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R7: accepted start raises busy
    a_r7_start_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10: no valid lookup during a run
    a_r10_no_valid: assert property (@(posedge clk) disable iff (rst)
        busy |-> !rd_valid);

    // R10: lookup data held during a run
    a_r10_data_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(rd_data));

    // R9: table writes by the engine only happen inside a run
    a_r9_eng_write_busy: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> busy);

endmodule

bind remask_engine remask_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .eng_we    (eng_we),
    .pick_fire (pick_fire),
    .pick_bit  (pick_bit)
);

// File: tb/remask_engine_tb.sv
module remask_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW     = 4;
    localparam int DW     = 4;
    localparam int DEPTH  = 1 << AW;
    localparam int SW     = 3;
    localparam int HALF   = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [AW-1:0] mask;
    logic [SW-1:0] seed;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          rd_valid;
    logic          busy;
    logic          done;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    remask_engine #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .start(start), .mask(mask), .seed(seed),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_check(input int a, input int exp, input string req);
        rd_addr = AW'(a);
        @(negedge clk);
        chk(rd_valid && (int'(rd_data) == exp), req, int'(rd_data), exp);
    endtask

    task automatic write_entry(input int a, input int v);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(v);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic table_check(input string req);
        for (int a = 0; a < DEPTH; a++) read_check(a, int'(model[a]), req);
    endtask

    // Run one remask; optional intrusion during busy (R8, R9).
    task automatic remask(input int m, input int s, input bit intrude);
        int n;
        int exp_lat;
        bit vbad;
        bit dbad;
        logic [DW-1:0] held;
        logic [DW-1:0] nxt [DEPTH];
        held = rd_data;
        exp_lat = AW + 3 * HALF * $countones(AW'(m));
        mask = AW'(m); seed = SW'(s); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        rd_addr = rd_addr + 1'b1;
        n = 0; vbad = 0; dbad = 0;
        while (!done && n < 2000) begin
            if (rd_valid || !busy) vbad = 1;
            if (rd_data !== held) dbad = 1;
            if (intrude && n == 2) begin
                start = 1'b1; mask = ~AW'(m); wr_en = 1'b1;
                wr_addr = '0; wr_data = ~model[0];
            end
            if (intrude && n == 3) begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        chk(n == exp_lat, "R6 latency", n, exp_lat);
        chk(!vbad, "R10 rd_valid low and busy high during run", int'(vbad), 0);
        chk(!dbad, "R10 rd_data held during run", int'(dbad), 0);
        @(negedge clk);
        chk(!done && !busy, "R7 done pulse and busy release", int'({done, busy}), 0);
        for (int b = 0; b < DEPTH; b++) nxt[b ^ m] = model[b];
        for (int b = 0; b < DEPTH; b++) model[b] = nxt[b];
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R6 watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 0; mask = 0; seed = 0;
        wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(!busy && !done && !rd_valid, "R1 reset outputs", int'({busy, done, rd_valid}), 0);
        table_check("R1 table cleared");

        // R2: load a permutation and read it back
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = DW'((i * 7 + 3) % DEPTH);
            write_entry(i, int'(model[i]));
        end
        table_check("R2 load and lookup");

        // R4: zero mask leaves table in place
        remask(0, 5, 1'b0);
        table_check("R4 zero mask unchanged");

        // R3, R6: every mask with varied seeds
        for (int m = 1; m < DEPTH; m++) begin
            remask(m, (m * 5 + 1) % 8, 1'b0);
            table_check("R3 relocation b^M");
        end

        // R5: all seeds on the full mask give the same relocation
        for (int s = 0; s < 8; s++) begin
            remask(DEPTH - 1, s, 1'b0);
            table_check("R5 seed independence");
        end

        // R8, R9: start and write during a run are ignored
        remask(3, 2, 1'b1);
        table_check("R8 R9 intrusion ignored");
        begin
            bit extra;
            extra = 0;
            repeat (150) begin
                @(negedge clk);
                if (done || busy) extra = 1;
            end
            chk(!extra, "R8 no second run", int'(extra), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule